// File: doc/BRIEF.md
# Strided Block DMA Engine

The engine copies rectangular blocks between an 8 KB local memory and an 8 MB external memory. The local memory has two 4 KB banks. One command gives a direction, a local start address, an external start address and a packed length word. The engine moves one or more rows of equal length. Between rows it leaves a programmable gap in external memory only; on the local side the rows follow one another.

Both start addresses are aligned down to 8 bytes when a command is accepted. The row length is rounded up to a multiple of 8 bytes. When a row would run past the end of its local bank, that row is shortened so that it stops at the bank end. Each row length is computed again from the local address at which the row starts.

Every word moves through a single request/acknowledge handshake on the external side. The local side is a plain port with a combinational read and a synchronous write. Words whose local address lies in the lower bank have their byte order reversed; words in the upper bank pass through unchanged.

Top module: `dma_stride_engine`

## Requirements
- R1: `cmd_len_i` is decoded as follows. Bits 11:0 are the row length in bytes minus one. Bits 19:12 are the number of rows minus one. Bits 31:20 are the external gap in bytes that is added after each row.
- R2: On acceptance, bits 2:0 of both start addresses are cleared. The row length (field + 1) is rounded up to the next multiple of 8.
- R3: If the row's offset within its 4 KB local bank plus the rounded length exceeds 4096, that row moves only 4096 minus the offset bytes. The check is made again at the start of every row.
- R4: Word j of a row uses external word address (ext + 4j) bits 22:2, which wraps modulo 8 MB. It uses local word address (loc + 4j) bits 12:2, which wraps modulo 8 KB.
- R5: After each row, the local address grows by the row length and the external address grows by the row length plus the gap. `loc_addr_o` and `ext_addr_o` show the values after the last row once the command is done. Both outputs are 0 after reset.
- R6: A word whose local address has bit 12 = 0 is byte-reversed in either direction (byte 0 is exchanged with byte 3, and byte 1 with byte 2). A word whose local address has bit 12 = 1 is not changed.
- R7: When `cmd_dir_i` = 0 (read), external words are written into local memory. The local write happens on the same edge at which `ext_ack_i` accepts the word.
- R8: When `cmd_dir_i` = 1 (write), local words are written to external memory with `ext_we_o` = 1 and `ext_be_o` = 4'hF.
- R9: `busy_o` rises at the clock edge that accepts a command. It falls at the edge of the last word's acknowledge. A `cmd_valid_i` pulse while `busy_o` is high has no effect.
- R10: After reset, `busy_o` = 0, `ext_req_o` = 0 and `loc_we_o` = 0.
- R11: `ext_req_o` is high while a transfer is in progress. While `ext_req_o` is high and not yet acknowledged, the request address stays stable. Exactly one word advances per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_dir_i | input | 1 | 0: external to local, 1: local to external |
| cmd_loc_addr_i | input | 13 | Local start byte address |
| cmd_ext_addr_i | input | 23 | External start byte address |
| cmd_len_i | input | 32 | Packed length, row count and gap |
| busy_o | output | 1 | Command in progress |
| loc_addr_o | output | 13 | Current or final local byte address |
| ext_addr_o | output | 23 | Current or final external byte address |
| ext_req_o | output | 1 | External word request |
| ext_we_o | output | 1 | External write enable |
| ext_be_o | output | 4 | External byte enables |
| ext_word_addr_o | output | 21 | External word address |
| ext_wdata_o | output | 32 | External write data |
| ext_rdata_i | input | 32 | External read data, valid with ack |
| ext_ack_i | input | 1 | External word acknowledge |
| loc_word_addr_o | output | 11 | Local word address |
| loc_we_o | output | 1 | Local write enable |
| loc_wdata_o | output | 32 | Local write data |
| loc_rdata_i | input | 32 | Local read data, combinational |

## Verification
`busy_o` is high at the falling edge that follows the accepting edge. On a read transfer, each local write is due on the same edge as its external acknowledge, so the memory models are updated at that edge. `busy_o`, `loc_addr_o` and `ext_addr_o` reach their final values on the edge of the last acknowledge. The checks therefore wait for `busy_o` to be low at a falling edge and only then compare both memories and both address outputs against a model. The acknowledge is withheld in a pseudo-random pattern, and a falling-edge monitor checks the request address and byte enables in every stalled and every write cycle.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned LEN_W  = 12;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned SKIP_W = 12;
  localparam int unsigned CMDW   = LEN_W + CNT_W + SKIP_W;

  typedef struct packed {
    logic [SKIP_W-1:0] skip;
    logic [CNT_W-1:0]  rows_m1;
    logic [LEN_W-1:0]  len_m1;
  } len_word_t;

  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dma_dir_e;
endpackage

// File: rtl/dma_row_len.sv
module dma_row_len #(
  parameter int unsigned BANK_AW = 12,
  parameter int unsigned LEN_W   = 12,
  localparam int unsigned RL_W   = BANK_AW + 1
) (
  input  logic [LEN_W-1:0]   len_m1_i,
  input  logic [BANK_AW-1:0] bank_off_i,
  output logic [RL_W-1:0]    row_len_o
);
  localparam logic [RL_W:0] BANK_BYTES = (RL_W+1)'(1) << BANK_AW;

  logic [RL_W:0] len_rnd;
  logic [RL_W:0] row_end;
  logic [RL_W:0] room;

  always_comb begin
    len_rnd = ((RL_W+1)'(len_m1_i) + (RL_W+1)'(8)) & ~(RL_W+1)'(7);
    row_end = (RL_W+1)'(bank_off_i) + len_rnd;
    room    = BANK_BYTES - (RL_W+1)'(bank_off_i);
    row_len_o = (row_end > BANK_BYTES) ? room[RL_W-1:0] : len_rnd[RL_W-1:0];
  end
endmodule

// File: rtl/dma_swap.sv
module dma_swap #(
  parameter int unsigned DW = 32,
  localparam int unsigned NB = DW / 8
) (
  input  logic          swap_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign data_o[8*b +: 8] = swap_i ? data_i[8*(NB-1-b) +: 8] : data_i[8*b +: 8];
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int unsigned LOC_AW = 13,
  parameter int unsigned EXT_AW = 23,
  localparam int unsigned BANK_AW = LOC_AW - 1,
  localparam int unsigned RL_W    = BANK_AW + 1,
  localparam int unsigned WRD_W   = RL_W - 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic                cmd_dir_i,
  input  logic [LOC_AW-1:0]   cmd_loc_addr_i,
  input  logic [EXT_AW-1:0]   cmd_ext_addr_i,
  input  logic [CMDW-1:0]     cmd_len_i,
  input  logic                ext_ack_i,
  input  logic [RL_W-1:0]     row_len_i,
  output logic [LEN_W-1:0]    calc_len_m1_o,
  output logic [BANK_AW-1:0]  calc_off_o,
  output logic                busy_o,
  output logic                dir_o,
  output logic [LOC_AW-1:0]   loc_addr_o,
  output logic [EXT_AW-1:0]   ext_addr_o,
  output logic [LOC_AW-3:0]   loc_word_o,
  output logic [EXT_AW-3:0]   ext_word_o
);
  len_word_t          cfg_q;
  logic               busy_q, dir_q;
  logic [LOC_AW-1:0]  loc_q;
  logic [EXT_AW-1:0]  ext_q;
  logic [RL_W-1:0]    len_q;
  logic [WRD_W-1:0]   word_q;
  logic [CNT_W-1:0]   row_q;

  len_word_t          cmd_w;
  logic [LOC_AW-1:0]  loc_start, loc_nxt;
  logic [EXT_AW-1:0]  ext_start, ext_nxt;
  logic               row_last_word, last_ack, accept;

  assign cmd_w     = len_word_t'(cmd_len_i);
  assign loc_start = {cmd_loc_addr_i[LOC_AW-1:3], 3'b000};
  assign ext_start = {cmd_ext_addr_i[EXT_AW-1:3], 3'b000};
  assign loc_nxt   = loc_q + LOC_AW'(len_q);
  assign ext_nxt   = ext_q + EXT_AW'(len_q) + EXT_AW'(cfg_q.skip);

  assign row_last_word = (word_q == WRD_W'((len_q >> 2) - 1'b1));
  assign last_ack      = busy_q && ext_ack_i && row_last_word && (row_q == cfg_q.rows_m1);
  assign accept        = cmd_valid_i && !busy_q;

  // Row length is computed for the row about to start.
  assign calc_len_m1_o = busy_q ? cfg_q.len_m1 : cmd_w.len_m1;
  assign calc_off_o    = busy_q ? loc_nxt[BANK_AW-1:0] : loc_start[BANK_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      loc_q  <= '0;
      ext_q  <= '0;
      len_q  <= '0;
      word_q <= '0;
      row_q  <= '0;
    end else if (accept) begin
      cfg_q  <= cmd_w;
      busy_q <= 1'b1;
      dir_q  <= cmd_dir_i;
      loc_q  <= loc_start;
      ext_q  <= ext_start;
      len_q  <= row_len_i;
      word_q <= '0;
      row_q  <= '0;
    end else if (busy_q && ext_ack_i) begin
      if (row_last_word) begin
        loc_q  <= loc_nxt;
        ext_q  <= ext_nxt;
        word_q <= '0;
        len_q  <= row_len_i;
        row_q  <= row_q + 1'b1;
        if (last_ack) busy_q <= 1'b0;
      end else begin
        word_q <= word_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign dir_o      = dir_q;
  assign loc_addr_o = loc_q;
  assign ext_addr_o = ext_q;
  assign loc_word_o = loc_q[LOC_AW-1:2] + (LOC_AW-2)'(word_q);
  assign ext_word_o = ext_q[EXT_AW-1:2] + (EXT_AW-2)'(word_q);

  p_row_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (len_q[2:0] == 3'b000 && len_q != '0));
  p_row_in_bank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ((RL_W+1)'(loc_q[BANK_AW-1:0]) + (RL_W+1)'(len_q) <= ((RL_W+1)'(1) << BANK_AW)));
  p_cmd_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_valid_i && !last_ack) |=> (busy_q && $stable(dir_q) && $stable(cfg_q)));
  p_addr_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ext_ack_i) |=> ($stable(ext_word_o) && $stable(loc_word_o)));
endmodule

// File: rtl/dma_stride_engine.sv
module dma_stride_engine
  import dma_pkg::*;
#(
  parameter int unsigned LOC_AW = 13,
  parameter int unsigned EXT_AW = 23,
  parameter int unsigned DW     = 32,
  localparam int unsigned BANK_AW = LOC_AW - 1,
  localparam int unsigned RL_W    = BANK_AW + 1,
  localparam int unsigned NB      = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_dir_i,
  input  logic [LOC_AW-1:0] cmd_loc_addr_i,
  input  logic [EXT_AW-1:0] cmd_ext_addr_i,
  input  logic [CMDW-1:0]   cmd_len_i,
  output logic              busy_o,
  output logic [LOC_AW-1:0] loc_addr_o,
  output logic [EXT_AW-1:0] ext_addr_o,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic [NB-1:0]     ext_be_o,
  output logic [EXT_AW-3:0] ext_word_addr_o,
  output logic [DW-1:0]     ext_wdata_o,
  input  logic [DW-1:0]     ext_rdata_i,
  input  logic              ext_ack_i,
  output logic [LOC_AW-3:0] loc_word_addr_o,
  output logic              loc_we_o,
  output logic [DW-1:0]     loc_wdata_o,
  input  logic [DW-1:0]     loc_rdata_i
);
  logic [RL_W-1:0]    row_len;
  logic [LEN_W-1:0]   calc_len_m1;
  logic [BANK_AW-1:0] calc_off;
  logic               busy, dir;
  logic               low_bank;

  dma_row_len #(.BANK_AW(BANK_AW), .LEN_W(LEN_W)) u_row_len (
    .len_m1_i   (calc_len_m1),
    .bank_off_i (calc_off),
    .row_len_o  (row_len)
  );

  dma_seq #(.LOC_AW(LOC_AW), .EXT_AW(EXT_AW)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_dir_i      (cmd_dir_i),
    .cmd_loc_addr_i (cmd_loc_addr_i),
    .cmd_ext_addr_i (cmd_ext_addr_i),
    .cmd_len_i      (cmd_len_i),
    .ext_ack_i      (ext_ack_i),
    .row_len_i      (row_len),
    .calc_len_m1_o  (calc_len_m1),
    .calc_off_o     (calc_off),
    .busy_o         (busy),
    .dir_o          (dir),
    .loc_addr_o     (loc_addr_o),
    .ext_addr_o     (ext_addr_o),
    .loc_word_o     (loc_word_addr_o),
    .ext_word_o     (ext_word_addr_o)
  );

  assign low_bank = !loc_word_addr_o[LOC_AW-3];

  dma_swap #(.DW(DW)) u_swap_wr (
    .swap_i (low_bank),
    .data_i (loc_rdata_i),
    .data_o (ext_wdata_o)
  );

  dma_swap #(.DW(DW)) u_swap_rd (
    .swap_i (low_bank),
    .data_i (ext_rdata_i),
    .data_o (loc_wdata_o)
  );

  assign busy_o    = busy;
  assign ext_req_o = busy;
  assign ext_we_o  = busy && (dir == DIR_WR);
  assign ext_be_o  = {NB{ext_we_o}};
  assign loc_we_o  = busy && (dir == DIR_RD) && ext_ack_i;

  p_loc_we_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_we_o |-> (ext_req_o && ext_ack_i && !ext_we_o));
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ext_req_o && !loc_we_o));
endmodule

// File: tb/sim_dma_stride_engine.sv
module sim_dma_stride_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_dir_i = 1'b0;
  logic [12:0] cmd_loc_addr_i = '0;
  logic [22:0] cmd_ext_addr_i = '0;
  logic [31:0] cmd_len_i = '0;
  logic        busy_o;
  logic [12:0] loc_addr_o;
  logic [22:0] ext_addr_o;
  logic        ext_req_o, ext_we_o, ext_ack_i, loc_we_o;
  logic [3:0]  ext_be_o;
  logic [20:0] ext_word_addr_o;
  logic [31:0] ext_wdata_o, ext_rdata_i, loc_wdata_o, loc_rdata_i;
  logic [10:0] loc_word_addr_o;

  logic [31:0] loc_mem [2048];
  logic [31:0] ext_mem [4096];
  logic [31:0] exp_loc [2048];
  logic [31:0] exp_ext [4096];
  logic [7:0]  lfsr = 8'h5B;
  logic        ack_en;
  int checks = 0, failures = 0, cyc = 0;
  int stall_bad = 0, be_bad = 0, stalls = 0;
  logic        prev_stall = 1'b0;
  logic [20:0] prev_addr = '0;
  int exp_loc_fin, exp_ext_fin;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_stride_engine u0 (.*);

  assign ack_en      = lfsr[0] | lfsr[1];
  assign ext_ack_i   = ext_req_o && ack_en;
  assign ext_rdata_i = ext_mem[ext_word_addr_o[11:0]];
  assign loc_rdata_i = loc_mem[loc_word_addr_o];

  always @(posedge clk_i) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (ext_req_o && ext_ack_i && ext_we_o) ext_mem[ext_word_addr_o[11:0]] <= ext_wdata_o;
    if (loc_we_o) loc_mem[loc_word_addr_o] <= loc_wdata_o;
  end

  always @(negedge clk_i) begin
    if (prev_stall) begin
      stalls++;
      if (ext_word_addr_o != prev_addr) stall_bad++;
    end
    prev_stall = ext_req_o && !ext_ack_i;
    prev_addr  = ext_word_addr_o;
    if (ext_req_o && ext_we_o && ext_be_o != 4'hF) be_bad++;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WDOG) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic seed_mem();
    for (int i = 0; i < 2048; i++) begin
      loc_mem[i] = {16'hA5C3 ^ 16'(i * 7), 16'(i)};
      exp_loc[i] = loc_mem[i];
    end
    for (int i = 0; i < 4096; i++) begin
      ext_mem[i] = {16'h3C5A ^ 16'(i * 13), 16'h1000 + 16'(i)};
      exp_ext[i] = ext_mem[i];
    end
  endtask

  // Model built from R1..R6
  task automatic model(input bit dir, input int loc, input int ext, input int len);
    int lenb, cnt, skip, l, e, rl, la, ea;
    lenb = (((len & 'hFFF) + 1) + 7) & ~7;
    cnt  = (len >> 12) & 'hFF;
    skip = (len >> 20) & 'hFFF;
    l = loc & 'h1FF8;
    e = ext & 'h7FFFF8;
    for (int r = 0; r <= cnt; r++) begin
      rl = lenb;
      if ((l & 'hFFF) + rl > 4096) rl = 4096 - (l & 'hFFF);
      for (int j = 0; j < rl; j += 4) begin
        la = (l + j) & 'h1FFC;
        ea = (e + j) & 'h7FFFFC;
        if (!dir)
          exp_loc[la >> 2] = (la & 'h1000) ? exp_ext[(ea >> 2) & 'hFFF] : swap32(exp_ext[(ea >> 2) & 'hFFF]);
        else
          exp_ext[(ea >> 2) & 'hFFF] = (la & 'h1000) ? exp_loc[la >> 2] : swap32(exp_loc[la >> 2]);
      end
      l = (l + rl) & 'h1FFF;
      e = (e + rl + skip) & 'h7FFFFF;
    end
    exp_loc_fin = l;
    exp_ext_fin = e;
  endtask

  task automatic issue(input bit dir, input int loc, input int ext, input int len, input int hold);
    @(negedge clk_i);
    cmd_dir_i = dir;
    cmd_loc_addr_i = 13'(loc);
    cmd_ext_addr_i = 23'(ext);
    cmd_len_i = 32'(len);
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b1, "R9 busy after accept", busy_o, 1);
    if (hold > 0) begin
      cmd_dir_i = ~dir;
      cmd_loc_addr_i = 13'h0400;
      cmd_ext_addr_i = 23'h000A00;
      cmd_len_i = 32'h0000_3FFF;
      repeat (hold) @(negedge clk_i);
    end
    cmd_valid_i = 1'b0;
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic compare(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < 2048; i++) if (loc_mem[i] !== exp_loc[i]) begin bad++; if (first < 0) first = i; end
    if (first >= 0) chk(1'b0, {req, " local memory"}, loc_mem[first], exp_loc[first]);
    else chk(1'b1, req, 0, 0);
    first = -1;
    for (int i = 0; i < 4096; i++) if (ext_mem[i] !== exp_ext[i]) begin bad++; if (first < 0) first = i; end
    if (first >= 0) chk(1'b0, {req, " external memory"}, ext_mem[first], exp_ext[first]);
    else chk(1'b1, req, 0, 0);
    chk(loc_addr_o == 13'(exp_loc_fin), "R5 final local address", loc_addr_o, exp_loc_fin);
    chk(ext_addr_o == 23'(exp_ext_fin), "R5 final external address", ext_addr_o, exp_ext_fin);
    chk(busy_o == 1'b0, "R9 busy low after last ack", busy_o, 0);
  endtask

  task automatic run(input string req, input bit dir, input int loc, input int ext, input int len);
    seed_mem();
    model(dir, loc, ext, len);
    issue(dir, loc, ext, len, 0);
    compare(req);
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0, "R10 busy at reset", busy_o, 0);
    chk(ext_req_o == 1'b0, "R10 request at reset", ext_req_o, 0);
    chk(loc_we_o == 1'b0, "R10 local write at reset", loc_we_o, 0);
    chk(loc_addr_o == 13'h0 && ext_addr_o == 23'h0, "R5 addresses at reset", {loc_addr_o, ext_addr_o}, 0);
  endtask

  task automatic t_ignore_busy();
    seed_mem();
    model(1'b0, 'h1300, 'h600, 32'h0020_101F);
    issue(1'b0, 'h1300, 'h600, 32'h0020_101F, 4);
    compare("R9 command while busy ignored");
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_ni = 1'b1;
    // R7 R6 R1: read into lower bank, swapped
    run("R7 R6 read lower bank", 1'b0, 'h0010, 'h000100, 32'h0000_000F);
    // R2: unaligned starts, 6-byte length rounds to 8, upper bank unswapped
    run("R2 R6 align and round", 1'b0, 'h100B, 'h000203, 32'h0000_0005);
    // R1 R5: three rows, gap 16
    run("R1 R5 multi-row with gap", 1'b0, 'h1100, 'h000400, 32'h0100_2007);
    // R3: first row clamped at bank end, second starts in upper bank
    run("R3 bank end clamp", 1'b0, 'h0FF0, 'h000800, 32'h0000_101F);
    // R3: maximal length from bank start is not clamped
    run("R3 full bank row", 1'b0, 'h1000, 'h000000, 32'h0000_0FFF);
    // R8 R6: write from lower bank, swapped, gap 8
    run("R8 R6 write lower bank", 1'b1, 'h0020, 'h000800, 32'h0080_100B);
    // R8: write from upper bank unswapped
    run("R8 write upper bank", 1'b1, 'h1840, 'h000C00, 32'h0000_2017);
    // R4: external wrap at 8 MB
    run("R4 external wrap", 1'b0, 'h1200, 'h7FFFF8, 32'h0000_000F);
    // R4: local wrap past top of upper bank into lower bank
    run("R4 local wrap", 1'b1, 'h1FF8, 'h000300, 32'h0000_1007);
    t_ignore_busy();
    chk(stall_bad == 0 && stalls > 0, "R11 address stable while stalled", stall_bad, 0);
    chk(be_bad == 0, "R8 byte enables all set on writes", be_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule